// File: doc/BRIEF.md
# Burst Dynamic Memory Refresh Controller

This block keeps the contents of dynamic memories on a shared bus alive. An interval timer runs while the enable strap is set. When it expires, the block requests the bus. Once the bus is granted, it runs a burst of back-to-back refresh cycles, one for each row. During each refresh cycle it drives a bus-wide refresh strobe and the row address, so every dynamic memory on the bus refreshes the same row at the same time.

A DMA master does not have to wait for the whole burst. Its request is examined at the end of each refresh cycle except the last. If the request is present, the block passes the bus to the DMA master. When the master lets go, the burst resumes at the next row. External interrupts are masked from the moment the bus is requested until the last row is done. The default interval is about 1.6 ms, which stays inside a 2 ms retention limit.

When the strap is cleared, the block stays idle and passes an externally generated refresh strobe onto the same strobe line.

Top module: `refresh_burst_ctrl`

## Requirements
- R1: After reset, busReq, dmaGrant, refStrobe and irqMask are 0 and rowAddr is 0.
- R2: With refreshEn at 1 and every burst finishing within the interval, busReq rises once every INTERVAL_TICKS+1 clocks. INTERVAL_TICKS is CLK_HZ/1e6 × INTERVAL_NS / 1000.
- R3: A burst holds busReq at 1 from the request to its end. Its refresh cycles start only after busGrant is seen. It runs 2^ROW_W refresh cycles on rows 0, 1, 2 and so on in ascending order. In each cycle refStrobe is 1 for exactly CYC_CLKS clocks.
- R4: If dmaReq is 1 on the last clock of a refresh cycle that is not the final one, dmaGrant is 1 from the next clock and refStrobe is 0 meanwhile. One clock after dmaReq drops, dmaGrant returns to 0 and refresh resumes at the next row, with no row skipped or repeated.
- R5: irqMask is 1 from the rise of busReq to the end of the burst, including DMA gaps, and 0 when idle.
- R6: With refreshEn at 0, busReq never rises and refStrobe follows extRefStrobe in the same cycle.
- R7: With refreshEn at 1, extRefStrobe is ignored: refStrobe is 1 only during the block's own refresh cycles.
- R8: If the interval expires while a burst is in progress, one more burst is pending. busReq goes to 0 for exactly one clock after the burst ends and then rises again.
- R9: rowAddr advances by one after each refresh cycle and wraps from 2^ROW_W−1 to 0, so it is 0 between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshEn | input | 1 | Enable strap for automatic refresh |
| busGrant | input | 1 | Bus granted to this block |
| dmaReq | input | 1 | DMA master requests the bus |
| extRefStrobe | input | 1 | Externally generated refresh strobe |
| busReq | output | 1 | Bus request for a burst |
| dmaGrant | output | 1 | Bus passed to the DMA master between refresh cycles |
| refStrobe | output | 1 | Bus-wide refresh strobe |
| rowAddr | output | ROW_W | Row being refreshed |
| irqMask | output | 1 | Masks external interrupts during a burst |

## Verification
Two things can fall in the same cycle: the end of a refresh cycle and a DMA request. The bench raises dmaReq in the middle of a refresh cycle, so the request is present at the cycle's last clock. It then checks three things: the grant appears on the next clock, the strobe stays low while the grant is held, and the scoreboard still sees every row in order. A second overlap comes from holding busGrant off long enough that the interval expires inside a burst. The bench then checks that the bus is released for exactly one clock before the pending burst begins.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_CYCLE = 2'd2,
    ST_DMA   = 2'd3
  } refState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startBurst; // restart interval timer, consume pending burst
    logic cycRun;     // advance cycle clock counter
    logic rowStep;    // advance row counter
  } ctlStrobes_t;
endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int ROW_W          = 6,
  parameter int CYC_CLKS       = 4,
  parameter int INTERVAL_TICKS = 200000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapOn,
  input  ctlStrobes_t      ctl,
  output logic             pending,
  output logic             cycLast,
  output logic             rowLast,
  output logic [ROW_W-1:0] rowAddr
);
  localparam int TIMER_W = (INTERVAL_TICKS > 2) ? $clog2(INTERVAL_TICKS) : 1;
  localparam int CYC_W   = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [TIMER_W-1:0] TIMER_MAX = TIMER_W'(INTERVAL_TICKS - 1);
  localparam logic [CYC_W-1:0]   CYC_MAX   = CYC_W'(CYC_CLKS - 1);
  localparam logic [ROW_W-1:0]   ROW_MAX   = '1;

  logic [TIMER_W-1:0] timer;
  logic [CYC_W-1:0]   cycCnt;
  logic [ROW_W-1:0]   row;

  // interval timer and single pending-burst flag
  always_ff @(posedge clk) begin
    if (!rstN || !strapOn) begin
      timer   <= '0;
      pending <= 1'b0;
    end else if (ctl.startBurst) begin
      timer   <= '0;
      pending <= 1'b0;
    end else if (timer == TIMER_MAX) begin
      timer   <= '0;
      pending <= 1'b1;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  // clocks within one refresh cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (ctl.cycRun) begin
      cycCnt <= (cycCnt == CYC_MAX) ? '0 : cycCnt + 1'b1;
    end
  end

  // row counter, wraps naturally at 2^ROW_W
  always_ff @(posedge clk) begin
    if (!rstN) begin
      row <= '0;
    end else if (ctl.rowStep) begin
      row <= row + 1'b1;
    end
  end

  assign cycLast = (cycCnt == CYC_MAX);
  assign rowLast = (row == ROW_MAX);
  assign rowAddr = row;
endmodule

// File: rtl/refresh_ctl.sv
module refresh_ctl
  import refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pending,
  input  logic        busGrant,
  input  logic        dmaReq,
  input  logic        cycLast,
  input  logic        rowLast,
  output ctlStrobes_t ctl,
  output logic        busReq,
  output logic        dmaGrant,
  output logic        ownStrobe,
  output logic        irqMask
);
  refState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (pending) stateNxt = ST_REQ;
      ST_REQ:   if (busGrant) stateNxt = ST_CYCLE;
      ST_CYCLE: if (cycLast) begin
                  if (rowLast)     stateNxt = ST_IDLE;
                  else if (dmaReq) stateNxt = ST_DMA;
                end
      ST_DMA:   if (!dmaReq) stateNxt = ST_CYCLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.startBurst = (state == ST_IDLE) && pending;
    ctl.cycRun     = (state == ST_CYCLE);
    ctl.rowStep    = (state == ST_CYCLE) && cycLast;
  end

  assign busReq    = (state != ST_IDLE);
  assign irqMask   = (state != ST_IDLE);
  assign dmaGrant  = (state == ST_DMA);
  assign ownStrobe = (state == ST_CYCLE);
endmodule

// File: rtl/refresh_burst_ctrl.sv
module refresh_burst_ctrl
  import refresh_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int INTERVAL_NS = 1_600_000,
  parameter int ROW_W       = 6,
  parameter int CYC_CLKS    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refreshEn,
  input  logic             busGrant,
  input  logic             dmaReq,
  input  logic             extRefStrobe,
  output logic             busReq,
  output logic             dmaGrant,
  output logic             refStrobe,
  output logic [ROW_W-1:0] rowAddr,
  output logic             irqMask
);
  localparam int INTERVAL_TICKS = (CLK_HZ / 1_000_000) * INTERVAL_NS / 1000;

  ctlStrobes_t ctl;
  logic pending, cycLast, rowLast, ownStrobe;

  refresh_dp #(
    .ROW_W(ROW_W), .CYC_CLKS(CYC_CLKS), .INTERVAL_TICKS(INTERVAL_TICKS)
  ) dp (
    .clk(clk), .rstN(rstN), .strapOn(refreshEn), .ctl(ctl),
    .pending(pending), .cycLast(cycLast), .rowLast(rowLast), .rowAddr(rowAddr)
  );

  refresh_ctl ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .busGrant(busGrant),
    .dmaReq(dmaReq), .cycLast(cycLast), .rowLast(rowLast), .ctl(ctl),
    .busReq(busReq), .dmaGrant(dmaGrant), .ownStrobe(ownStrobe), .irqMask(irqMask)
  );

  // external strobe shares the line only when automatic refresh is strapped off
  assign refStrobe = ownStrobe | (!refreshEn & extRefStrobe);
endmodule

// File: rtl/refresh_burst_chk.sv
module refresh_burst_chk #(
  parameter int ROW_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             refreshEn,
  input logic             busReq,
  input logic             dmaGrant,
  input logic             refStrobe,
  input logic             irqMask,
  input logic [ROW_W-1:0] rowAddr
);
  // R3
  strobe_needs_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshEn && refStrobe |-> busReq);

  // R4
  dma_inside_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaGrant |-> busReq);

  // R4
  dma_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshEn && dmaGrant |-> !refStrobe);

  // R5
  mask_during_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshEn && refStrobe) || dmaGrant |-> irqMask);

  // R6
  no_request_strapped_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refreshEn && !busReq |=> !busReq);

  // R7
  ext_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshEn && !busReq |-> !refStrobe);

  // R9
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rowAddr) |-> rowAddr == ROW_W'($past(rowAddr) + 1'b1));
endmodule

bind refresh_burst_ctrl refresh_burst_chk #(.ROW_W(ROW_W)) chk (
  .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .busReq(busReq),
  .dmaGrant(dmaGrant), .refStrobe(refStrobe), .irqMask(irqMask), .rowAddr(rowAddr)
);

// File: tb/refresh_burst_ctrl_test.sv
module refresh_burst_ctrl_test;
  localparam int ROW_W = 6;
  localparam int ROWS  = 1 << ROW_W;
  localparam int CYC   = 4;
  localparam int TICKS = 400; // 125 MHz, 3200 ns

  logic clk = 0, rstN = 0, refreshEn = 1, dmaReq = 0, extRefStrobe = 0, grantOk = 1;
  logic busReq, dmaGrant, refStrobe, irqMask, busGrant;
  logic [ROW_W-1:0] rowAddr;

  int errors = 0, checks = 0;
  int expRows[$];
  logic prevOwn = 0;
  logic [ROW_W-1:0] prevRow = '0;
  int runLen = 0;
  int cycNow = 0;

  always #4 clk = ~clk;
  assign busGrant = busReq & grantOk;

  refresh_burst_ctrl #(.CLK_HZ(125_000_000), .INTERVAL_NS(3200), .ROW_W(ROW_W), .CYC_CLKS(CYC)) uut (
    .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .busGrant(busGrant), .dmaReq(dmaReq),
    .extRefStrobe(extRefStrobe), .busReq(busReq), .dmaGrant(dmaGrant), .refStrobe(refStrobe),
    .rowAddr(rowAddr), .irqMask(irqMask)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectBurst();
    for (int r = 0; r < ROWS; r++) expRows.push_back(r);
  endtask

  task automatic waitReqRise();
    while (busReq) @(negedge clk);
    while (!busReq) @(negedge clk);
  endtask

  task automatic waitReqFall();
    while (busReq) @(negedge clk);
  endtask

  always @(negedge clk) cycNow++;

  // monitor / scoreboard for the block's own refresh cycles
  always @(negedge clk) begin
    logic own;
    own = refStrobe && busReq;
    if (rstN) begin
      if (prevOwn && (!own || rowAddr != prevRow))
        check(runLen == CYC, "R3 strobe length", runLen, CYC);
      if (own && (!prevOwn || rowAddr != prevRow)) begin
        if (expRows.size() == 0) begin
          check(0, "R3 unexpected refresh row", int'(rowAddr), -1);
        end else begin
          int e;
          e = expRows.pop_front();
          check(int'(rowAddr) == e, "R3 row order", int'(rowAddr), e);
        end
        runLen = 1;
      end else if (own) begin
        runLen++;
      end
      if (own) check(irqMask == 1'b1, "R5 mask during refresh", irqMask, 1);
    end
    prevOwn = own;
    prevRow = rowAddr;
  end

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t1, t2, lowCnt;
    expectBurst(); expectBurst(); expectBurst(); expectBurst();
    repeat (3) @(negedge clk);
    check(busReq == 0, "R1 busReq", busReq, 0);
    check(refStrobe == 0, "R1 refStrobe", refStrobe, 0);
    check(irqMask == 0, "R1 irqMask", irqMask, 0);
    check(dmaGrant == 0, "R1 dmaGrant", dmaGrant, 0);
    check(rowAddr == 0, "R1 rowAddr", int'(rowAddr), 0);
    rstN = 1;

    // burst 1
    waitReqRise(); t1 = cycNow;
    check(irqMask == 1, "R5 mask at request", irqMask, 1);
    waitReqFall();
    check(irqMask == 0, "R5 mask idle", irqMask, 0);
    check(rowAddr == 0, "R9 row wrap", int'(rowAddr), 0);

    // burst 2 with DMA interleave
    waitReqRise(); t2 = cycNow;
    check(t2 - t1 == TICKS + 1, "R2 interval", t2 - t1, TICKS + 1);
    repeat (10) @(negedge clk);
    dmaReq = 1;
    while (!dmaGrant) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      check(refStrobe == 0, "R4 no strobe in DMA", refStrobe, 0);
      check(irqMask == 1, "R5 mask in DMA", irqMask, 1);
      @(negedge clk);
    end
    dmaReq = 0;
    @(negedge clk);
    check(dmaGrant == 0, "R4 grant released", dmaGrant, 0);
    check(refStrobe == 1, "R4 refresh resumes", refStrobe, 1);
    waitReqFall();

    // burst 3 delayed grant, interval expires inside it
    grantOk = 0;
    waitReqRise();
    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 0) begin
        check(refStrobe == 0, "R3 no strobe before grant", refStrobe, 0);
        check(irqMask == 1, "R5 mask while waiting", irqMask, 1);
      end
      @(negedge clk);
    end
    grantOk = 1;
    waitReqFall();
    lowCnt = 0;
    while (!busReq && lowCnt < 5) begin lowCnt++; @(negedge clk); end
    check(lowCnt == 1, "R8 pending burst gap", lowCnt, 1);
    waitReqFall(); // burst 4 done

    // strap off
    refreshEn = 0;
    for (int i = 0; i < 1000; i++) begin
      if (busReq) begin check(0, "R6 request while off", 1, 0); break; end
      @(negedge clk);
    end
    check(busReq == 0, "R6 idle while off", busReq, 0);
    extRefStrobe = 1; #1;
    check(refStrobe == 1, "R6 external strobe passes", refStrobe, 1);
    extRefStrobe = 0; #1;
    check(refStrobe == 0, "R6 external strobe released", refStrobe, 0);

    // strap on, external ignored
    @(negedge clk);
    refreshEn = 1; extRefStrobe = 1;
    repeat (5) @(negedge clk);
    check(refStrobe == 0, "R7 external ignored", refStrobe, 1'b0);
    extRefStrobe = 0;
    check(expRows.size() == 0, "R3 all rows seen", expRows.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule